// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block keeps wall-clock time and calendar date as eight byte-wide BCD registers, advanced by a single-cycle 100 Hz tick pulse from elsewhere in the chip. Each tick moves the hundredths counter forward. Carries ripple up through seconds, minutes, hours, day of week, date, month and year. The date rolls over at the correct month length, including February in leap years.

Software-side logic loads any register as a whole byte through a parallel write port. It reads any register back through a combinational read port. The hours byte carries a 12/24-hour select and, in 12-hour mode, an AM/PM flag. The day-of-week byte also holds two control bits. One stops all counting. The other decides whether an external active-low reset input is allowed to raise an abort indication for whatever transfer logic sits next to the block.

Register indices are: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week plus control, 5 date, 6 month, 7 year. The day of week counts 1 to 7.

Top module: `cal_timekeeper`

## Requirements
- R1: After synchronous reset, registers 0..7 read 00, 00, 00, 00, 31, 01, 01, 00 (hex). The oscillator-stop and reset-enable bits therefore start at 1, and the hours start in 24-hour mode.
- R2: A write stores the byte ANDed with the register's live-bit mask. The masks are FF, 7F, 7F, BF, 37, 3F, 1F, FF for indices 0..7. Masked-off bits read as 0, and the new value is readable in the cycle after the write.
- R3: When a tick is accepted, hundredths count 00..99, and seconds and minutes count 00..59, in BCD. Each field wraps to 00 and carries into the next field on the same tick.
- R4: With hours bit 7 = 0 (24-hour mode), hours bits 5:0 count 00..23 in BCD. The step from 23 to 00 advances the day of week and the date.
- R5: With hours bit 7 = 1 (12-hour mode), bits 4:0 hold 01..12 in BCD and bit 5 = 1 means PM. The sequence 11 to 12 flips bit 5, and 12 goes to 01. Only 11 PM to 12 AM advances the day of week and the date.
- R6: While register 4 bit 5 is 1, ticks change no register.
- R7: Day of week (register 4 bits 2:0) counts 1..7 and steps from 7 to 1. Register 4 bits 5:4 are left unchanged by counting.
- R8: The date wraps to 01 after 31 for months 01, 03, 05, 07, 08, 10 and 12, and after 30 for months 04, 06, 09 and 11. For February it wraps after 29 when the BCD year is a multiple of 4 (00 included), and after 28 otherwise.
- R9: The date wrapping advances the month. Month 12 goes to 01 and advances the year, and year 99 goes to 00.
- R10: In a cycle with both a write and a tick, the write is applied and the tick is discarded. No counter advances in that cycle.
- R11: Output `xfer_abort` is 1 exactly when `ext_rst_n` is 0 and register 4 bit 4 is 0. With bit 4 = 1 the external input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 100 Hz |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Index of register to write |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 3 | Index of register to read |
| rd_data | output | 8 | Combinational read data |
| ext_rst_n | input | 1 | External active-low reset request |
| xfer_abort | output | 1 | Abort indication for the neighbouring transfer logic |

## Verification
The two functions that can meet in one clock are a register load and an accepted tick, and the tick may be one that would ripple carries through several fields. The bench presets the hundredths to 99, then issues a write to another register together with a tick. It expects the written byte to appear and every counter, hundredths included, to hold its value. Random traffic repeats the collision many times. A bench-side calendar model, stepped under the same rule, judges every register after every cycle.

// File: rtl/cal_pkg.sv
// Shared constants and BCD helpers for the calendar core.
// Assumes all fields are 8-bit BCD bytes addressed by a 3-bit index.
package cal_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned REG_N  = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        IDX_HUND  = 3'd0,
        IDX_SEC   = 3'd1,
        IDX_MIN   = 3'd2,
        IDX_HOUR  = 3'd3,
        IDX_DAY   = 3'd4,
        IDX_DATE  = 3'd5,
        IDX_MONTH = 3'd6,
        IDX_YEAR  = 3'd7
    } cal_idx_e;

    // Next BCD value of a two-digit byte (no wrap handling).
    function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Live-bit mask of each register.
    function automatic logic [DATA_W-1:0] reg_mask(input logic [ADDR_W-1:0] a);
        case (a)
            IDX_SEC, IDX_MIN: return 8'h7F;
            IDX_HOUR:         return 8'hBF;
            IDX_DAY:          return 8'h37;
            IDX_DATE:         return 8'h3F;
            IDX_MONTH:        return 8'h1F;
            default:          return 8'hFF;
        endcase
    endfunction

    // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6.
    function automatic logic bcd_leap(input logic [DATA_W-1:0] y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    // Last date of a BCD month in a BCD year.
    function automatic logic [DATA_W-1:0] month_len(input logic [DATA_W-1:0] m,
                                                    input logic [DATA_W-1:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_wrap_ctr.sv
// Two-digit BCD counter that wraps from a runtime limit to a fixed low value.
// Assumes load and step are never both wanted; load wins if they are.
module cal_wrap_ctr
    import cal_pkg::*;
#(
    parameter logic [DATA_W-1:0] LO  = 8'h00,
    parameter logic [DATA_W-1:0] RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] val,
    output logic              carry
);
    logic [DATA_W-1:0] val_q;

    // Holds the count: reset, load, or BCD step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)     val_q <= RST;
        else if (ld)    val_q <= ld_val;
        else if (step)  val_q <= (val_q == hi) ? LO : bcd_inc(val_q);
    end

    assign val   = val_q;
    assign carry = step && (val_q == hi);

    AST_WRAP_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && val_q == hi) |=> (val_q == LO)); // R3
endmodule

// File: rtl/cal_hour_ctr.sv
// Hours byte counter: bit 7 picks 12-hour mode, bit 5 is PM or tens-of-hours bit.
// Assumes the stored value was written in the format of its mode.
module cal_hour_ctr
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              ld,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] val,
    output logic              day_carry
);
    logic [DATA_W-1:0] hr_q;
    logic [DATA_W-1:0] nxt;
    logic              wrap;

    // Computes the next hours byte and whether a new day starts.
    always_comb begin
        nxt  = hr_q;
        wrap = 1'b0;
        if (hr_q[7]) begin
            if (hr_q[4:0] == 5'h11) begin
                nxt[4:0] = 5'h12;
                nxt[5]   = ~hr_q[5];
                wrap     = hr_q[5];
            end else if (hr_q[4:0] == 5'h12) begin
                nxt[4:0] = 5'h01;
            end else begin
                nxt[4:0] = bcd_inc({3'b000, hr_q[4:0]})[4:0];
            end
        end else begin
            if (hr_q[5:0] == 6'h23) begin
                nxt[5:0] = 6'h00;
                wrap     = 1'b1;
            end else begin
                nxt[5:0] = bcd_inc({2'b00, hr_q[5:0]})[5:0];
            end
        end
    end

    // Holds the hours byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     hr_q <= '0;
        else if (ld)    hr_q <= ld_val;
        else if (step)  hr_q <= nxt;
    end

    assign val       = hr_q;
    assign day_carry = step && wrap;

    AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && hr_q[7] && hr_q[4:0] == 5'h11) |=> (hr_q[5] != $past(hr_q[5]))); // R5
    AST_DAY_WRAP_24: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !hr_q[7] && hr_q[5:0] == 6'h23) |=> (hr_q[5:0] == 6'h00)); // R4
endmodule

// File: rtl/cal_timekeeper.sv
// Calendar core: eight BCD registers advanced by a 100 Hz tick, byte write/read ports.
// Assumes tick is a one-cycle pulse; a write in the same cycle discards the tick.
module cal_timekeeper
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_rst_n,
    output logic              xfer_abort
);
    logic [REG_N-1:0]  ld;
    logic [DATA_W-1:0] ld_val;
    logic [DATA_W-1:0] regs [REG_N];
    logic [DATA_W-1:0] day_q;
    logic              run;
    logic              c_hund, c_sec, c_min, c_day, c_date, c_month, c_year;

    assign ld_val = wr_data & reg_mask(wr_addr);
    assign run    = tick && !day_q[5] && !wr_en;

    // One load strobe per register index.
    for (genvar i = 0; i < REG_N; i++) begin : g_ld
        assign ld[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    cal_wrap_ctr #(.LO(8'h00), .RST(8'h00)) u_hund (
        .clk(clk), .rst_n(rst_n), .step(run), .ld(ld[IDX_HUND]), .ld_val(ld_val),
        .hi(8'h99), .val(regs[IDX_HUND]), .carry(c_hund));
    cal_wrap_ctr #(.LO(8'h00), .RST(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .step(c_hund), .ld(ld[IDX_SEC]), .ld_val(ld_val),
        .hi(8'h59), .val(regs[IDX_SEC]), .carry(c_sec));
    cal_wrap_ctr #(.LO(8'h00), .RST(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .step(c_sec), .ld(ld[IDX_MIN]), .ld_val(ld_val),
        .hi(8'h59), .val(regs[IDX_MIN]), .carry(c_min));
    cal_hour_ctr u_hour (
        .clk(clk), .rst_n(rst_n), .step(c_min), .ld(ld[IDX_HOUR]), .ld_val(ld_val),
        .val(regs[IDX_HOUR]), .day_carry(c_day));
    cal_wrap_ctr #(.LO(8'h01), .RST(8'h01)) u_date (
        .clk(clk), .rst_n(rst_n), .step(c_day), .ld(ld[IDX_DATE]), .ld_val(ld_val),
        .hi(month_len(regs[IDX_MONTH], regs[IDX_YEAR])), .val(regs[IDX_DATE]), .carry(c_date));
    cal_wrap_ctr #(.LO(8'h01), .RST(8'h01)) u_month (
        .clk(clk), .rst_n(rst_n), .step(c_date), .ld(ld[IDX_MONTH]), .ld_val(ld_val),
        .hi(8'h12), .val(regs[IDX_MONTH]), .carry(c_month));
    cal_wrap_ctr #(.LO(8'h00), .RST(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .step(c_month), .ld(ld[IDX_YEAR]), .ld_val(ld_val),
        .hi(8'h99), .val(regs[IDX_YEAR]), .carry(c_year));

    // Day-of-week counter sharing its byte with the stop and reset-enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)            day_q <= 8'h31;
        else if (ld[IDX_DAY])  day_q <= ld_val;
        else if (c_day)        day_q[2:0] <= (day_q[2:0] == 3'd7) ? 3'd1 : day_q[2:0] + 3'd1;
    end

    assign regs[IDX_DAY] = day_q;
    assign rd_data       = regs[rd_addr];
    assign xfer_abort    = !ext_rst_n && !day_q[4];

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (day_q[5] && !wr_en) |=> ($stable(regs[IDX_HUND]) && $stable(regs[IDX_SEC])
                                  && $stable(regs[IDX_HOUR]) && $stable(day_q)
                                  && $stable(regs[IDX_DATE]) && $stable(regs[IDX_YEAR]))); // R6
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_addr)] == ($past(wr_data) & reg_mask($past(wr_addr))))); // R2
    AST_TICK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != IDX_HUND) |=> $stable(regs[IDX_HUND])); // R10
    AST_MONTH_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        c_date |=> !$stable(regs[IDX_MONTH])); // R9
    AST_YEAR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        c_year |=> (regs[IDX_YEAR] == 8'h00)); // R9
endmodule

// File: tb/cal_timekeeper_bench.sv
module cal_timekeeper_bench;
    localparam int PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_rst_n = 1'b1;
    logic       xfer_abort;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic [7:0] m [8];

    always #(PER/2) clk = ~clk;

    cal_timekeeper u_cal_timekeeper (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_rst_n(ext_rst_n), .xfer_abort(xfer_abort));

    function automatic logic [7:0] to_bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] mask_of(input int a);
        logic [7:0] t [8] = '{8'hFF, 8'h7F, 8'h7F, 8'hBF, 8'h37, 8'h3F, 8'h1F, 8'hFF};
        return t[a];
    endfunction

    function automatic int last_day(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    // Model of one accepted tick, written from the requirements.
    task automatic model_tick();
        int h; int v; bit pm; bit nd;
        if (m[4][5]) return;
        v = from_bcd(m[0]) + 1; if (v < 100) begin m[0] = to_bcd(v); return; end
        m[0] = 8'h00;
        v = from_bcd(m[1]) + 1; if (v < 60) begin m[1] = to_bcd(v); return; end
        m[1] = 8'h00;
        v = from_bcd(m[2]) + 1; if (v < 60) begin m[2] = to_bcd(v); return; end
        m[2] = 8'h00;
        nd = 0;
        if (m[3][7]) begin
            h = from_bcd({3'b0, m[3][4:0]}); pm = m[3][5];
            if (h == 11) begin h = 12; pm = ~pm; nd = !pm; end
            else if (h == 12) h = 1;
            else h = h + 1;
            m[3] = {1'b1, 1'b0, pm, to_bcd(h)[4:0]};
        end else begin
            h = from_bcd({2'b0, m[3][5:0]});
            if (h == 23) begin h = 0; nd = 1; end else h = h + 1;
            m[3] = to_bcd(h);
        end
        if (!nd) return;
        m[4][2:0] = (m[4][2:0] == 3'd7) ? 3'd1 : m[4][2:0] + 3'd1;
        v = from_bcd(m[5]);
        if (v < last_day(from_bcd(m[6]), from_bcd(m[7]))) begin m[5] = to_bcd(v + 1); return; end
        m[5] = 8'h01;
        v = from_bcd(m[6]); if (v < 12) begin m[6] = to_bcd(v + 1); return; end
        m[6] = 8'h01;
        m[7] = to_bcd((from_bcd(m[7]) + 1) % 100);
    endtask

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Reads every register through the port and compares to the model.
    task automatic compare_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #(PER/20);
            check(tag, $sformatf("reg%0d", a), rd_data, m[a]);
        end
        check(tag, "xfer_abort", {7'b0, xfer_abort}, {7'b0, !ext_rst_n && !m[4][4]});
    endtask

    // One clock with the given stimulus, model update, then port comparison.
    task automatic cycle(input bit w, input int a, input logic [7:0] d, input bit t, input string tag);
        @(negedge clk);
        wr_en = w; wr_addr = 3'(a); wr_data = d; tick = t;
        @(posedge clk);
        if (w) m[a] = d & mask_of(a);
        else if (t) model_tick();
        #(PER/4);
        wr_en = 0; tick = 0;
        compare_all(tag);
    endtask

    task automatic put(input int a, input logic [7:0] d, input string tag);
        cycle(1, a, d, 0, tag);
    endtask

    task automatic preset(input logic [7:0] hr, input logic [7:0] dy, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
        put(0, 8'h99, "R2"); put(1, 8'h59, "R2"); put(2, 8'h59, "R2");
        put(3, hr, "R2"); put(4, dy, "R2"); put(5, dt, "R2"); put(6, mo, "R2"); put(7, yr, "R2");
    endtask

    function automatic logic [7:0] rand_val(input int a);
        case (a)
            0: return to_bcd($urandom % 100);
            1, 2: return to_bcd($urandom % 60);
            3: if ($urandom % 2) return {2'b10, 1'($urandom % 2), to_bcd(1 + $urandom % 12)[4:0]};
               else return to_bcd($urandom % 24);
            4: return {3'b000, 1'($urandom % 2), 1'b0, 3'(1 + $urandom % 7)};
            5: return to_bcd(1 + $urandom % 28);
            6: return to_bcd(1 + $urandom % 12);
            default: return to_bcd($urandom % 100);
        endcase
    endfunction

    initial begin
        #(PER * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1248));
        m = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h01, 8'h00};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #(PER/4);
        compare_all("R1");
        // R11: reset-enable bit set, external request ignored
        ext_rst_n = 0; #1; compare_all("R11");
        // R6: stopped after reset, tick has no effect
        cycle(0, 0, 8'h00, 1, "R6");
        // start oscillator, reset-enable clear: abort follows the pin
        put(4, 8'h01, "R11");
        ext_rst_n = 1; #1; compare_all("R11");
        // R2: all-ones writes show the masks
        for (int a = 0; a < 8; a++) put(a, 8'hFF, "R2");
        // R3 R4 R7 R9: full rollover at year end, 24-hour mode
        preset(8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        cycle(0, 0, 8'h00, 1, "R4 R7 R9");
        cycle(0, 0, 8'h00, 1, "R3");
        // R8: leap and common Februaries, 30-day month
        preset(8'h23, 8'h02, 8'h28, 8'h02, 8'h24); cycle(0, 0, 8'h00, 1, "R8");
        put(0, 8'h99, "R2"); put(1, 8'h59, "R2"); put(2, 8'h59, "R2"); put(3, 8'h23, "R2");
        cycle(0, 0, 8'h00, 1, "R8");
        preset(8'h23, 8'h02, 8'h28, 8'h02, 8'h23); cycle(0, 0, 8'h00, 1, "R8");
        preset(8'h23, 8'h02, 8'h28, 8'h02, 8'h00); cycle(0, 0, 8'h00, 1, "R8");
        preset(8'h23, 8'h02, 8'h30, 8'h04, 8'h31); cycle(0, 0, 8'h00, 1, "R8");
        // R5: 12-hour sequence
        preset(8'h91, 8'h03, 8'h10, 8'h05, 8'h30); cycle(0, 0, 8'h00, 1, "R5");
        preset(8'hB1, 8'h03, 8'h10, 8'h05, 8'h30); cycle(0, 0, 8'h00, 1, "R5");
        preset(8'h92, 8'h03, 8'h10, 8'h05, 8'h30); cycle(0, 0, 8'h00, 1, "R5");
        // R10: write and tick collide, hundredths stay at 99
        put(0, 8'h99, "R2");
        cycle(1, 2, 8'h30, 1, "R10");
        // R6: stop bit set, ticks ignored
        put(4, 8'h25, "R6");
        cycle(0, 0, 8'h00, 1, "R6"); cycle(0, 0, 8'h00, 1, "R6");
        put(4, 8'h05, "R7");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int r; int a;
            r = $urandom % 100;
            a = $urandom % 8;
            ext_rst_n = 1'($urandom % 2);
            if (r < 70)      cycle(0, 0, 8'h00, 1, "R3");
            else if (r < 85) cycle(1, a, rand_val(a), 0, "R2");
            else if (r < 95) cycle(1, a, rand_val(a), 1, "R10");
            else             cycle(0, 0, 8'h00, 0, "R11");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule